// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block takes a three-wire serial audio stream (bit clock, word clock and serial data) together with a serial C2 erasure-flag line that runs in step with the data. It turns the stream into parallel 16-bit left and right samples. All four serial inputs are oversampled by the system clock through a synchronizer. Bit-clock edges are detected in the system-clock domain. On each selected edge, the word clock, the data line and the flag line are captured.

One 8-bit framing byte controls the capture. It selects the latching edge, the data bit order, the flag bit order, which word-clock level marks the left channel, how many bit clocks after a word-clock change capture starts, and whether the capture window is exactly 16 bits wide. This lets one receiver accept several serial formats that do not work with each other. Once a left word and the right word after it are complete, the block presents both samples with their 16-bit flag words and strobes a one-cycle valid. It also keeps a sticky error byte, which is the OR of every flag byte seen since the last block start.

Top module: `audio_serial_rx`

## Requirements
- R1: After reset, `cfg_o`, `left_o`, `right_o`, `c2_flags_o` and `blk_err_o` are all zero and `frame_valid_o` is low.
- R2: A write with `cfg_we` high stores `cfg_wdata` with bit 3 forced to 0, and `cfg_o` shows the stored byte from the next cycle on. Without a write, the byte holds.
- R3: Framing bit 0 picks the latching bit-clock edge: 1 for rising, 0 for falling.
- R4: Framing bit 1 picks the data bit order: 1 means the first captured bit is bit 15 of the sample, 0 means the first captured bit is bit 0.
- R5: Bit position 0 is the bit latched on the first edge after a word-clock change. With framing bit 2 at 1, exactly 16 bits are captured, at positions offset to offset+15, and all other bits are ignored. With framing bit 2 at 0, capture runs from the offset until the next word-clock change, and the sample is the last 16 bits captured.
- R6: The offset equals framing bit 6 plus 8 times framing bit 4.
- R7: Framing bit 5 gives the left-channel word-clock level: 1 means bits latched while the word clock is high form the left sample, 0 means low.
- R8: The flag line is latched at the same positions as the data. Framing bit 7 gives its order (1 means first captured flag is bit 15). `c2_flags_o` holds the right flag word in bits 31:16 and the left flag word in bits 15:0.
- R9: `frame_valid_o` pulses for exactly one cycle when a right half ends that directly follows a complete left half. A sample or flag output changes only in that cycle. A half that did not start at a word-clock change seen after reset is never delivered.
- R10: On each valid cycle, `blk_err_o` is ORed with all four bytes of the new `c2_flags_o`, and it is not cleared by later frames.
- R11: `blk_start` clears `blk_err_o` in the next cycle. If a frame is delivered in that same cycle, only that frame's flag bytes remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Word (left/right) clock |
| sdata_i | input | 1 | Serial audio data |
| c2_i | input | 1 | Serial C2 erasure flags |
| cfg_we | input | 1 | Framing byte write strobe |
| cfg_wdata | input | 8 | Framing byte write data |
| blk_start | input | 1 | Start of block; clears the error byte |
| cfg_o | output | 8 | Stored framing byte |
| left_o | output | 16 | Left sample |
| right_o | output | 16 | Right sample |
| c2_flags_o | output | 32 | Right and left flag words |
| frame_valid_o | output | 1 | One-cycle strobe for a new frame |
| blk_err_o | output | 8 | Sticky OR of flag bytes |

## Verification
The assertions assume that the word clock, data and flag lines are stable at every latching bit-clock edge. They also assume that each bit-clock level lasts long enough for the synchronizer to see it, and that the framing byte is not rewritten in the middle of a frame. The bench holds each bit-clock level for four system clocks. It changes data, flags and word clock only together with the non-latching bit-clock transition. It writes the framing byte only right after a reset, before any stream starts.

// File: rtl/arx_pkg.sv
package arx_pkg;
    typedef struct packed {
        logic c2_msb;     // flag line bit order
        logic off1;       // one-clock offset
        logic left_high;  // left channel on high word clock
        logic dly8;       // extra delay
        logic rsvd;       // always stored as zero
        logic sel16;      // fixed 16-bit window
        logic msb;        // data bit order
        logic rise;       // latching edge
    } arx_ctrl_t;

    localparam logic [7:0] ARX_CTRL_MASK = 8'hF7;
endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.chain[STAGES-1];
endmodule

// File: rtl/arx_slot.sv
module arx_slot #(
    parameter int PW         = 6,
    parameter int WORD       = 16,
    parameter int LATE_SHIFT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic lr,
    input  logic sel16,
    input  logic off1,
    input  logic dly8,
    input  logic left_high,
    output logic trans_o,
    output logic cap_o,
    output logic end_ok_o,
    output logic end_left_o
);
    localparam logic [PW-1:0] POS_MAX = '1;

    typedef struct packed {
        logic          lr;
        logic          lrv;
        logic          started;
        logic [PW-1:0] pos;
    } slot_t;

    slot_t         s_d, s_q;
    logic          lr_chg;
    logic          in_win;
    logic [PW-1:0] pos_now;
    logic [PW-1:0] off;
    logic [PW:0]   lim;

    always_comb begin
        s_d    = s_q;
        lr_chg = s_q.lrv && (lr != s_q.lr);
        if (lr_chg)                  pos_now = '0;
        else if (s_q.pos == POS_MAX) pos_now = POS_MAX;
        else                         pos_now = s_q.pos + 1'b1;
        off    = (dly8 ? PW'(LATE_SHIFT) : '0) + {{(PW-1){1'b0}}, off1};
        lim    = {1'b0, off} + (PW+1)'(WORD);
        in_win = (pos_now >= off) && (!sel16 || ({1'b0, pos_now} < lim));

        trans_o    = evt && lr_chg;
        cap_o      = evt && in_win;
        end_ok_o   = evt && lr_chg && s_q.started;
        end_left_o = (s_q.lr == left_high);

        if (evt) begin
            s_d.lr  = lr;
            s_d.lrv = 1'b1;
            s_d.pos = pos_now;
            if (lr_chg) s_d.started = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/arx_shift.sv
module arx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         cap,
    input  logic         bit_in,
    input  logic         msb_first,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_d, word_q;
    logic [W-1:0] base;

    always_comb begin
        base   = clr ? '0 : word_q;
        word_d = base;
        if (cap) begin
            if (msb_first) word_d = {base[W-2:0], bit_in};
            else           word_d = {bit_in, base[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word_o = word_q;
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
    parameter int WORD        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int POS_W       = 6,
    parameter int LATE_SHIFT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck_i,
    input  logic              lrck_i,
    input  logic              sdata_i,
    input  logic              c2_i,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              blk_start,
    output logic [7:0]        cfg_o,
    output logic [WORD-1:0]   left_o,
    output logic [WORD-1:0]   right_o,
    output logic [2*WORD-1:0] c2_flags_o,
    output logic              frame_valid_o,
    output logic [7:0]        blk_err_o
);
    import arx_pkg::*;

    localparam int NBYTE = (2 * WORD) / 8;

    typedef struct packed {
        logic [7:0]        cfg;
        logic              bck;
        logic [WORD-1:0]   lhold;
        logic [WORD-1:0]   lflag;
        logic              have_left;
        logic [WORD-1:0]   left;
        logic [WORD-1:0]   right;
        logic [2*WORD-1:0] flags;
        logic              valid;
        logic [7:0]        blkerr;
    } top_t;

    top_t s_d, s_q;

    logic [3:0] sy;
    logic       bck_s, lr_s, sd_s, c2_s;
    arx_ctrl_t  ctrl;
    logic       evt;
    logic       trans, cap, end_ok, end_left;
    logic [1:0][WORD-1:0] words;
    logic [1:0] shift_bit, shift_msb;
    logic [2*WORD-1:0] new_flags;
    logic [7:0] fold;
    logic       deliver;

    arx_sync #(.W(4), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bck_i, lrck_i, sdata_i, c2_i}),
        .dout (sy)
    );

    assign {bck_s, lr_s, sd_s, c2_s} = sy;
    assign ctrl = arx_ctrl_t'(s_q.cfg);
    assign evt  = ctrl.rise ? (bck_s & ~s_q.bck) : (~bck_s & s_q.bck);

    arx_slot #(.PW(POS_W), .WORD(WORD), .LATE_SHIFT(LATE_SHIFT)) i_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .lr        (lr_s),
        .sel16     (ctrl.sel16),
        .off1      (ctrl.off1),
        .dly8      (ctrl.dly8),
        .left_high (ctrl.left_high),
        .trans_o   (trans),
        .cap_o     (cap),
        .end_ok_o  (end_ok),
        .end_left_o(end_left)
    );

    assign shift_bit = {c2_s, sd_s};
    assign shift_msb = {ctrl.c2_msb, ctrl.msb};

    // lane 0 carries audio data, lane 1 carries erasure flags
    for (genvar g = 0; g < 2; g++) begin : g_lane
        arx_shift #(.W(WORD)) i_shift (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (trans),
            .cap      (cap),
            .bit_in   (shift_bit[g]),
            .msb_first(shift_msb[g]),
            .word_o   (words[g])
        );
    end

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.bck   = bck_s;
        deliver   = 1'b0;
        new_flags = {words[1], s_q.lflag};
        fold      = '0;
        for (int i = 0; i < NBYTE; i++) begin
            fold = fold | new_flags[i*8 +: 8];
        end

        if (cfg_we) s_d.cfg = cfg_wdata & ARX_CTRL_MASK;

        if (end_ok) begin
            if (end_left) begin
                s_d.lhold     = words[0];
                s_d.lflag     = words[1];
                s_d.have_left = 1'b1;
            end else if (s_q.have_left) begin
                s_d.left      = s_q.lhold;
                s_d.right     = words[0];
                s_d.flags     = new_flags;
                s_d.valid     = 1'b1;
                s_d.have_left = 1'b0;
                deliver       = 1'b1;
            end
        end

        if (blk_start)    s_d.blkerr = deliver ? fold : 8'h00;
        else if (deliver) s_d.blkerr = s_q.blkerr | fold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_o         = s_q.cfg;
    assign left_o        = s_q.left;
    assign right_o       = s_q.right;
    assign c2_flags_o    = s_q.flags;
    assign frame_valid_o = s_q.valid;
    assign blk_err_o     = s_q.blkerr;
endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk #(
    parameter int WORD = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [7:0]        cfg_wdata,
    input logic              blk_start,
    input logic [7:0]        cfg_o,
    input logic [WORD-1:0]   left_o,
    input logic [WORD-1:0]   right_o,
    input logic [2*WORD-1:0] c2_flags_o,
    input logic              frame_valid_o,
    input logic [7:0]        blk_err_o
);
    localparam int NBYTE = (2 * WORD) / 8;

    logic [7:0] fold;
    always_comb begin
        fold = '0;
        for (int i = 0; i < NBYTE; i++) fold = fold | c2_flags_o[i*8 +: 8];
    end

    a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_o == ($past(cfg_wdata) & 8'hF7)));

    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_o));

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |=> !frame_valid_o);

    a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid_o |-> ($stable(left_o) && $stable(right_o) && $stable(c2_flags_o)));

    a_r10_covers_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |-> ((blk_err_o | fold) == blk_err_o));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_start |=> ((blk_err_o & $past(blk_err_o)) == $past(blk_err_o)));

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> (frame_valid_o || (blk_err_o == 8'h00)));
endmodule

bind audio_serial_rx audio_serial_rx_chk #(.WORD(WORD)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .blk_start    (blk_start),
    .cfg_o        (cfg_o),
    .left_o       (left_o),
    .right_o      (right_o),
    .c2_flags_o   (c2_flags_o),
    .frame_valid_o(frame_valid_o),
    .blk_err_o    (blk_err_o)
);

// File: tb/test_audio_serial_rx.sv
module test_audio_serial_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bck = 1'b0, lrck = 1'b0, sdata = 1'b0, c2 = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        blk_start = 1'b0;
    logic [7:0]  cfg_o;
    logic [15:0] left_o, right_o;
    logic [31:0] c2_flags_o;
    logic        frame_valid_o;
    logic [7:0]  blk_err_o;

    int total = 0, fails = 0;
    int rx_cnt = 0;
    int wide_pulse = 0;
    bit done = 0;
    logic prev_v = 1'b0;
    logic [15:0] rx_l [4];
    logic [15:0] rx_r [4];
    logic [31:0] rx_f [4];

    always #4 clk = ~clk;  // 125 MHz

    audio_serial_rx i_audio_serial_rx (
        .clk(clk), .rst_n(rst_n), .bck_i(bck), .lrck_i(lrck), .sdata_i(sdata),
        .c2_i(c2), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .blk_start(blk_start),
        .cfg_o(cfg_o), .left_o(left_o), .right_o(right_o), .c2_flags_o(c2_flags_o),
        .frame_valid_o(frame_valid_o), .blk_err_o(blk_err_o)
    );

    // monitor: record delivered frames, flag any strobe longer than one cycle
    always @(negedge clk) begin
        if (frame_valid_o) begin
            rx_l[rx_cnt % 4] = left_o;
            rx_r[rx_cnt % 4] = right_o;
            rx_f[rx_cnt % 4] = c2_flags_o;
            rx_cnt = rx_cnt + 1;
            if (prev_v) wide_pulse = wide_pulse + 1;
        end
        prev_v = frame_valid_o;
    end

    // {framing byte, left, right, left flags, right flags}
    localparam logic [71:0] VEC [8] = '{
        72'h07_A55A_1234_0001_8000,
        72'h24_8001_7FFE_0100_0000,
        72'hA3_C3C3_0F0F_0000_4002,
        72'hC3_1357_9BDF_1000_0020,
        72'h16_FFFF_0000_0000_0000,
        72'h52_5A5A_A5A5_0080_0401,
        72'h5F_2468_ACE0_8000_0008,
        72'h00_0F1E_E1F0_0010_0200
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic drive_bit(input logic rise, input logic lr, input logic d, input logic f);
        @(negedge clk);
        bck = rise ? 1'b0 : 1'b1;   // non-latching transition
        lrck = lr;
        sdata = d;
        c2 = f;
        repeat (4) @(negedge clk);
        bck = ~bck;                 // latching transition
        repeat (3) @(negedge clk);
    endtask

    task automatic send_half(input logic [7:0] c, input logic lr,
                             input logic [15:0] w, input logic [15:0] f);
        int off, st, k;
        off = (c[6] ? 1 : 0) + (c[4] ? 8 : 0);
        st  = c[2] ? off : 16;
        for (int p = 0; p < 32; p++) begin
            k = p - st;
            if (k >= 0 && k < 16)
                drive_bit(c[0], lr, w[c[1] ? 15 - k : k], f[c[7] ? 15 - k : k]);
            else
                drive_bit(c[0], lr, 1'b1, 1'b1);
        end
    endtask

    task automatic lead_in(input logic [7:0] c);
        for (int i = 0; i < 4; i++) drive_bit(c[0], ~c[5], 1'b1, 1'b1);
    endtask

    function automatic logic [7:0] fold4(input logic [31:0] v);
        return v[7:0] | v[15:8] | v[23:16] | v[31:24];
    endfunction

    initial begin
        int base;
        logic [7:0] c;
        logic [7:0] acc;

        do_reset();
        // R1: reset state
        check("R1 cfg", {24'h0, cfg_o}, 32'h0);
        check("R1 left", {16'h0, left_o}, 32'h0);
        check("R1 right", {16'h0, right_o}, 32'h0);
        check("R1 flags", c2_flags_o, 32'h0);
        check("R1 valid", {31'h0, frame_valid_o}, 32'h0);
        check("R1 blkerr", {24'h0, blk_err_o}, 32'h0);

        // R2: reserved bit dropped, value held
        write_cfg(8'hFF);
        check("R2 rsvd", {24'h0, cfg_o}, 32'h0000_00F7);
        repeat (5) @(negedge clk);
        check("R2 hold", {24'h0, cfg_o}, 32'h0000_00F7);

        // R3..R8, R10: table of framing modes
        for (int v = 0; v < 8; v++) begin
            c = VEC[v][71:64];
            do_reset();
            write_cfg(c);
            check("R2 cfg", {24'h0, cfg_o}, {24'h0, c & 8'hF7});
            base = rx_cnt;
            lead_in(c);
            send_half(c, c[5], VEC[v][63:48], VEC[v][31:16]);
            send_half(c, ~c[5], VEC[v][47:32], VEC[v][15:0]);
            drive_bit(c[0], c[5], 1'b0, 1'b0);
            repeat (16) @(negedge clk);
            check("R9 count", rx_cnt - base, 1);
            check("R3 R4 R5 R6 R7 left", {16'h0, rx_l[base % 4]}, {16'h0, VEC[v][63:48]});
            check("R3 R4 R5 R6 R7 right", {16'h0, rx_r[base % 4]}, {16'h0, VEC[v][47:32]});
            check("R8 flags", rx_f[base % 4], {VEC[v][15:0], VEC[v][31:16]});
            check("R10 blkerr", {24'h0, blk_err_o}, {24'h0, fold4({VEC[v][15:0], VEC[v][31:16]})});
        end

        // R9, R10: three frames in a row, error byte accumulates
        do_reset();
        write_cfg(8'h07);
        base = rx_cnt;
        acc = 8'h00;
        lead_in(8'h07);
        for (int n = 0; n < 3; n++) begin
            send_half(8'h07, 1'b0, 16'h1111 * 16'(n + 1), 16'h0001 << n);
            send_half(8'h07, 1'b1, 16'hF0F0 ^ 16'(n), 16'h0100 << (n + 2));
            acc = acc | fold4({16'h0100 << (n + 2), 16'h0001 << n});
        end
        drive_bit(1'b1, 1'b0, 1'b0, 1'b0);
        repeat (16) @(negedge clk);
        check("R9 three frames", rx_cnt - base, 3);
        for (int n = 0; n < 3; n++) begin
            check("R9 stream left", {16'h0, rx_l[(base + n) % 4]}, {16'h0, 16'h1111 * 16'(n + 1)});
            check("R9 stream right", {16'h0, rx_r[(base + n) % 4]}, {16'h0, 16'hF0F0 ^ 16'(n)});
        end
        check("R10 accumulate", {24'h0, blk_err_o}, {24'h0, acc});
        check("R9 single-cycle strobe", wide_pulse, 0);

        // R11: block start clears
        @(negedge clk);
        blk_start = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
        check("R11 clear", {24'h0, blk_err_o}, 32'h0);

        // R9: partial half before reset is discarded
        do_reset();
        write_cfg(8'h07);
        lead_in(8'h07);
        send_half(8'h07, 1'b0, 16'hDEAD, 16'hFFFF);
        do_reset();
        write_cfg(8'h07);
        base = rx_cnt;
        lead_in(8'h07);
        send_half(8'h07, 1'b0, 16'h4321, 16'h0000);
        send_half(8'h07, 1'b1, 16'h8765, 16'h0000);
        drive_bit(1'b1, 1'b0, 1'b0, 1'b0);
        repeat (16) @(negedge clk);
        check("R9 after reset count", rx_cnt - base, 1);
        check("R9 after reset left", {16'h0, rx_l[base % 4]}, 32'h0000_4321);
        check("R1 R10 no stale flags", {24'h0, blk_err_o}, 32'h0);

        // R9: right half without a left half before it yields nothing
        do_reset();
        write_cfg(8'h07);
        base = rx_cnt;
        for (int i = 0; i < 4; i++) drive_bit(1'b1, 1'b0, 1'b1, 1'b1);
        send_half(8'h07, 1'b1, 16'h7777, 16'h00FF);
        drive_bit(1'b1, 1'b0, 1'b0, 1'b0);
        repeat (16) @(negedge clk);
        check("R9 lone right", rx_cnt - base, 0);
        check("R9 lone right outputs", {16'h0, right_o}, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule